// File: doc/BRIEF.md
# Console Halfword Display and Store Path

This block gives the operator console manual access, one halfword at a time, to several storage spaces. The spaces are the floating-point registers, the general registers, the current program status word, main storage, the instruction counter and the protection-key store. A 3-bit space code picks the target. The 16-bit console address and the 16-bit data keys are decoded. A display strobe or a store strobe, each one clock wide, then reads or writes a single halfword during that same clock.

The register files and main storage are outside the block. The block presents one access bus: a space code, an index, a write enable and write data. Read data returns combinationally on `acc_rdata_i`. The instruction counter is also external. Its live value enters on `ic_i`, and the block loads it through `ic_we_o`.

The results go to two registered lamp halfwords, the data lamps and the counter lamps. They change at the clock edge that ends the strobe cycle. Access works only while run control reports the manual state. A strobe at any other time does nothing except raise a one-cycle error pulse. Protection-key access belongs to another block, so strobes aimed at that space are dropped here.

Top module: `cc_console_path`

## Requirements
- R1: Space codes are 0 floating-point, 1 general, 2 current status word, 3 main storage, 4 instruction counter and 5 protection key. Codes 6 and 7 cause no access, no error and no lamp change.
- R2: For register spaces, address bits [7:4] give the register number and bits [1:0] give the halfword. Bits [3:2] and the high address byte are ignored. The access index is `{reg, hw}`, zero-extended.
- R3: Floating-point registers and the status word accept halfword codes 0 to 3, and general registers accept 0 and 1. A general-register strobe with code 2 or 3 makes no access, raises no error and leaves both lamp halfwords unchanged.
- R4: A main-storage access uses the address with bit 0 cleared. On display, the data lamps show the even byte in bits [15:8] and the odd byte in bits [7:0], whether the key address is even or odd.
- R5: A main-storage store writes both bytes of the pair from the data keys, as one halfword on the access bus.
- R6: At the edge that ends a store to a register space or main storage, the data lamps take the value of the data keys.
- R7: An instruction-counter display sets the data lamps to `{8'h00, ic[23:16]}` and the counter lamps to `ic[15:0]`.
- R8: An instruction-counter store loads the counter with the address keys, zero-extended to 24 bits. The lamps then show that new value in the R7 layout.
- R9: Outside the manual state, a strobe makes no access and leaves the lamps unchanged. `err_o` is high for exactly the one cycle after that strobe.
- R10: In the manual state, a strobe to the protection-key space makes no access, raises no error and leaves the lamps unchanged.
- R11: When display and store are strobed together, the store is performed.
- R12: After reset both lamp halfwords and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| manual_i | input | 1 | Run control reports the manual state |
| space_i | input | 3 | Target space code |
| addr_i | input | 16 | Console address keys |
| data_i | input | 16 | Console data keys |
| display_i | input | 1 | Display strobe, one cycle |
| store_i | input | 1 | Store strobe, one cycle |
| acc_space_o | output | 3 | Space code on the access bus |
| acc_index_o | output | 16 | Register index or even byte address |
| acc_we_o | output | 1 | Halfword write enable |
| acc_wdata_o | output | 16 | Halfword write data |
| acc_rdata_i | input | 16 | Halfword read data, combinational |
| ic_i | input | 24 | Current instruction counter |
| ic_we_o | output | 1 | Instruction counter load enable |
| ic_wdata_o | output | 24 | Instruction counter load value |
| data_lamp_o | output | 16 | Data lamp halfword |
| ic_lamp_o | output | 16 | Counter lamp halfword |
| err_o | output | 1 | Strobe outside the manual state |

## Verification
A wrong decode shows on the data lamps one edge after the strobe. Examples are an ignored address bit that is not ignored, or an odd byte address that is not forced even. The sweeps then read a value from the wrong register or the wrong byte pair. A store that leaks outside the manual state, or a store to a dropped general-register code, is not visible on the lamps at once. It shows on the next display of the same location, usually within two strobes. An error in the counter layout shows the wrong byte in one of the two lamp halfwords on the first counter display.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CC_ADDR_W = 16;
    localparam int CC_DATA_W = 16;
    localparam int CC_IC_W   = 24;

    typedef enum logic [2:0] {
        SP_FP  = 3'd0,
        SP_GP  = 3'd1,
        SP_PSW = 3'd2,
        SP_MS  = 3'd3,
        SP_IC  = 3'd4,
        SP_KEY = 3'd5
    } space_e;
endpackage

// File: rtl/cc_decode.sv
module cc_decode
    import cc_pkg::*;
#(
    parameter int ADDR_W = CC_ADDR_W
) (
    input  logic [2:0]        space_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              manual_i,
    input  logic              display_i,
    input  logic              store_i,
    output logic              act_o,
    output logic              wr_o,
    output logic              ic_o,
    output logic [ADDR_W-1:0] index_o,
    output logic              err_o
);
    localparam int REG_W = 4;
    localparam int HW_W  = 2;
    localparam int PAD_W = ADDR_W - REG_W - HW_W;

    logic strobe;
    logic legal;
    space_e sp;

    always_comb begin
        sp      = space_e'(space_i);
        strobe  = display_i | store_i;
        legal   = 1'b0;
        index_o = '0;
        case (sp)
            SP_FP, SP_PSW: begin
                legal   = 1'b1;
                index_o = {{PAD_W{1'b0}}, addr_i[7:4], addr_i[1:0]};
            end
            SP_GP: begin
                legal   = ~addr_i[1];
                index_o = {{PAD_W{1'b0}}, addr_i[7:4], addr_i[1:0]};
            end
            SP_MS: begin
                legal   = 1'b1;
                index_o = {addr_i[ADDR_W-1:1], 1'b0};
            end
            SP_IC:   legal = 1'b1;
            default: legal = 1'b0;
        endcase
        act_o = strobe & manual_i & legal;
        wr_o  = act_o & store_i;
        ic_o  = (sp == SP_IC);
        err_o = strobe & ~manual_i;
    end
endmodule

// File: rtl/cc_lamp_fmt.sv
module cc_lamp_fmt
    import cc_pkg::*;
#(
    parameter int ADDR_W = CC_ADDR_W,
    parameter int DATA_W = CC_DATA_W,
    parameter int IC_W   = CC_IC_W
) (
    input  logic              wr_i,
    input  logic              ic_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [IC_W-1:0]   ic_val_i,
    input  logic [DATA_W-1:0] ic_lamp_i,
    output logic [IC_W-1:0]   ic_new_o,
    output logic [DATA_W-1:0] data_lamp_o,
    output logic [DATA_W-1:0] ic_lamp_o
);
    localparam int HI_W  = IC_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;
    localparam int EXT_W = IC_W - ADDR_W;

    logic [IC_W-1:0] shown;

    always_comb begin
        ic_new_o = {{EXT_W{1'b0}}, addr_i};
        shown    = wr_i ? ic_new_o : ic_val_i;
        if (ic_i) begin
            data_lamp_o = {{PAD_W{1'b0}}, shown[IC_W-1:DATA_W]};
            ic_lamp_o   = shown[DATA_W-1:0];
        end else begin
            data_lamp_o = wr_i ? data_i : rdata_i;
            ic_lamp_o   = ic_lamp_i;
        end
    end
endmodule

// File: rtl/cc_console_path.sv
module cc_console_path
    import cc_pkg::*;
#(
    parameter int ADDR_W = CC_ADDR_W,
    parameter int DATA_W = CC_DATA_W,
    parameter int IC_W   = CC_IC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              manual_i,
    input  logic [2:0]        space_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              display_i,
    input  logic              store_i,
    output logic [2:0]        acc_space_o,
    output logic [ADDR_W-1:0] acc_index_o,
    output logic              acc_we_o,
    output logic [DATA_W-1:0] acc_wdata_o,
    input  logic [DATA_W-1:0] acc_rdata_i,
    input  logic [IC_W-1:0]   ic_i,
    output logic              ic_we_o,
    output logic [IC_W-1:0]   ic_wdata_o,
    output logic [DATA_W-1:0] data_lamp_o,
    output logic [DATA_W-1:0] ic_lamp_o,
    output logic              err_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data_lamp;
        logic [DATA_W-1:0] ic_lamp;
        logic              err;
    } state_t;

    state_t st_d, st_q;
    logic act, wr, is_ic, dec_err;
    logic [DATA_W-1:0] fmt_data, fmt_ic;

    cc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .space_i  (space_i),
        .addr_i   (addr_i),
        .manual_i (manual_i),
        .display_i(display_i),
        .store_i  (store_i),
        .act_o    (act),
        .wr_o     (wr),
        .ic_o     (is_ic),
        .index_o  (acc_index_o),
        .err_o    (dec_err)
    );

    cc_lamp_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IC_W(IC_W)) u_fmt (
        .wr_i       (wr),
        .ic_i       (is_ic),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .rdata_i    (acc_rdata_i),
        .ic_val_i   (ic_i),
        .ic_lamp_i  (st_q.ic_lamp),
        .ic_new_o   (ic_wdata_o),
        .data_lamp_o(fmt_data),
        .ic_lamp_o  (fmt_ic)
    );

    assign acc_space_o = space_i;
    assign acc_we_o    = wr & ~is_ic;
    assign acc_wdata_o = data_i;
    assign ic_we_o     = wr & is_ic;

    always_comb begin
        st_d     = st_q;
        st_d.err = dec_err;
        if (act) begin
            st_d.data_lamp = fmt_data;
            st_d.ic_lamp   = fmt_ic;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_lamp_o = st_q.data_lamp;
    assign ic_lamp_o   = st_q.ic_lamp;
    assign err_o       = st_q.err;

    AST_LAMPS_HOLD_OUTSIDE_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !manual_i |=> ($stable(data_lamp_o) && $stable(ic_lamp_o))); // R9
    AST_NO_WRITE_OUTSIDE_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we_o || ic_we_o) |-> manual_i); // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(!manual_i && (display_i || store_i))); // R9
    AST_MS_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we_o && space_i == 3'(SP_MS)) |-> !acc_index_o[0]); // R4
    AST_STORE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |=> data_lamp_o == $past(acc_wdata_o)); // R6
    AST_IC_LAMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ic_we_o |=> ic_lamp_o == $past(ic_wdata_o[DATA_W-1:0])); // R8
    AST_GP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (manual_i && space_i == 3'(SP_GP) && addr_i[1] && (display_i || store_i))
        |=> ($stable(data_lamp_o) && $stable(ic_lamp_o) && !err_o)); // R3
    AST_KEY_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (space_i == 3'(SP_KEY)) |-> !acc_we_o && !ic_we_o); // R10
endmodule

// File: tb/cc_console_path_test.sv
module cc_console_path_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic manual = 1'b1;
    logic [2:0] space = 3'd0;
    logic [15:0] addr = 16'h0, data = 16'h0;
    logic disp = 1'b0, stor = 1'b0;
    logic [2:0] acc_space;
    logic [15:0] acc_index, acc_wdata, acc_rdata;
    logic acc_we, ic_we, err;
    logic [23:0] ic_q, ic_wdata;
    logic [15:0] data_lamp, ic_lamp;

    logic [15:0] fp_m [16][4];
    logic [15:0] gp_m [16][2];
    logic [15:0] psw_m [4];
    logic [7:0]  ms_m [256];

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    cc_console_path uut (
        .clk(clk), .rst_n(rst_n), .manual_i(manual), .space_i(space),
        .addr_i(addr), .data_i(data), .display_i(disp), .store_i(stor),
        .acc_space_o(acc_space), .acc_index_o(acc_index), .acc_we_o(acc_we),
        .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata), .ic_i(ic_q),
        .ic_we_o(ic_we), .ic_wdata_o(ic_wdata), .data_lamp_o(data_lamp),
        .ic_lamp_o(ic_lamp), .err_o(err)
    );

    always_comb begin
        case (acc_space)
            3'd0: acc_rdata = fp_m[acc_index[5:2]][acc_index[1:0]];
            3'd1: acc_rdata = gp_m[acc_index[5:2]][acc_index[0]];
            3'd2: acc_rdata = psw_m[acc_index[1:0]];
            3'd3: acc_rdata = {ms_m[acc_index[7:0]], ms_m[acc_index[7:0] | 8'h01]};
            default: acc_rdata = 16'h0;
        endcase
    end

    always @(posedge clk) begin
        if (acc_we) begin
            case (acc_space)
                3'd0: fp_m[acc_index[5:2]][acc_index[1:0]] <= acc_wdata;
                3'd1: gp_m[acc_index[5:2]][acc_index[0]] <= acc_wdata;
                3'd2: psw_m[acc_index[1:0]] <= acc_wdata;
                3'd3: begin
                    ms_m[acc_index[7:0]] <= acc_wdata[15:8];
                    ms_m[acc_index[7:0] | 8'h01] <= acc_wdata[7:0];
                end
                default: ;
            endcase
        end
        if (ic_we) ic_q <= ic_wdata;
    end

    function automatic logic [15:0] fpv(int r, int h);
        return 16'(16'hA000 + r * 256 + h * 16 + (15 - r));
    endfunction
    function automatic logic [15:0] gpv(int r, int h);
        return 16'(16'h5000 + r * 4099 + h * 77);
    endfunction
    function automatic logic [7:0] msb(int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strike(input logic [2:0] sp, input logic [15:0] a,
                          input logic [15:0] d, input logic dsp, input logic st);
        @(negedge clk);
        space = sp; addr = a; data = d; disp = dsp; stor = st;
        @(negedge clk);
        disp = 1'b0; stor = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] held_d, held_i;
        for (int r = 0; r < 16; r++) begin
            for (int h = 0; h < 4; h++) fp_m[r][h] = fpv(r, h);
            for (int h = 0; h < 2; h++) gp_m[r][h] = gpv(r, h);
        end
        for (int h = 0; h < 4; h++) psw_m[h] = 16'(16'h0700 + h * 16'h1111);
        for (int i = 0; i < 256; i++) ms_m[i] = msb(i);
        ic_q = 24'h123456;
        repeat (3) @(negedge clk);
        check("R12 data lamp reset", 32'(data_lamp), 32'h0);
        check("R12 ic lamp reset", 32'(ic_lamp), 32'h0);
        check("R12 err reset", 32'(err), 32'h0);
        rst_n = 1'b1;

        // R1 R2 R3: floating-point sweep with noise in ignored bits
        for (int r = 0; r < 16; r++)
            for (int h = 0; h < 4; h++) begin
                strike(3'd0, 16'({r[3:0] ^ 4'h9, 4'(r)} << 8) | 16'(r * 16 + ((r & 3) << 2) + h),
                       16'hFFFF, 1'b1, 1'b0);
                check("R2 fp display", 32'(data_lamp), 32'(fpv(r, h)));
            end
        // R1 R3: general registers, halfword codes 0 and 1
        for (int r = 0; r < 16; r++)
            for (int h = 0; h < 2; h++) begin
                strike(3'd1, 16'(r * 16 + 12 + h), 16'h0, 1'b1, 1'b0);
                check("R3 gp display", 32'(data_lamp), 32'(gpv(r, h)));
            end
        // R3: general register codes 2 and 3 are no-ops, even for store
        held_d = data_lamp; held_i = ic_lamp;
        strike(3'd1, 16'h0032, 16'hDEAD, 1'b0, 1'b1);
        check("R3 gp code2 lamps", 32'(data_lamp), 32'(held_d));
        check("R3 gp code2 err", 32'(err), 32'h0);
        strike(3'd1, 16'h0033, 16'h0, 1'b1, 1'b0);
        check("R3 gp code3 lamps", 32'(data_lamp), 32'(held_d));
        check("R3 gp code3 ic lamps", 32'(ic_lamp), 32'(held_i));
        strike(3'd1, 16'h0030, 16'h0, 1'b1, 1'b0);
        check("R3 gp no write", 32'(data_lamp), 32'(gpv(3, 0)));
        // R3: status word halfwords, store then redisplay
        for (int h = 0; h < 4; h++) begin
            strike(3'd2, 16'(h), 16'h0, 1'b1, 1'b0);
            check("R3 psw display", 32'(data_lamp), 32'(16'h0700 + h * 16'h1111));
        end
        strike(3'd2, 16'h00F0, 16'h0BCD, 1'b0, 1'b1);
        check("R6 psw store echo", 32'(data_lamp), 32'h0BCD);
        strike(3'd2, 16'h0000, 16'h0, 1'b1, 1'b0);
        check("R6 psw readback", 32'(data_lamp), 32'h0BCD);
        // R6: floating-point store
        strike(3'd0, 16'h00A3, 16'h3C3C, 1'b0, 1'b1);
        check("R6 fp store echo", 32'(data_lamp), 32'h3C3C);
        strike(3'd0, 16'h00AF, 16'h0, 1'b1, 1'b0);
        check("R6 fp readback", 32'(data_lamp), 32'h3C3C);
        // R4: main storage sweep over even and odd addresses
        for (int a = 0; a < 256; a++) begin
            strike(3'd3, 16'((a ^ 8'h5A) << 8) | 16'(a), 16'h0, 1'b1, 1'b0);
            check("R4 ms display", 32'(data_lamp), 32'({msb(a & 254), msb(a | 1)}));
        end
        // R5: store at odd address writes the whole pair
        strike(3'd3, 16'h0041, 16'hBEEF, 1'b0, 1'b1);
        check("R6 ms store echo", 32'(data_lamp), 32'hBEEF);
        strike(3'd3, 16'h0040, 16'h0, 1'b1, 1'b0);
        check("R5 ms pair even", 32'(data_lamp), 32'hBEEF);
        strike(3'd3, 16'h003F, 16'h0, 1'b1, 1'b0);
        check("R5 ms neighbour", 32'(data_lamp), 32'({msb(62), msb(63)}));
        // R7 R8: instruction counter
        strike(3'd4, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R7 ic data lamp", 32'(data_lamp), 32'h0012);
        check("R7 ic lamp", 32'(ic_lamp), 32'h3456);
        strike(3'd4, 16'h8ABC, 16'hFFFF, 1'b0, 1'b1);
        check("R8 ic store data lamp", 32'(data_lamp), 32'h0000);
        check("R8 ic store ic lamp", 32'(ic_lamp), 32'h8ABC);
        strike(3'd4, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R8 ic redisplay", 32'(ic_lamp), 32'h8ABC);
        // R9: strobes outside the manual state
        held_d = data_lamp; held_i = ic_lamp;
        manual = 1'b0;
        strike(3'd3, 16'h0010, 16'h1111, 1'b0, 1'b1);
        check("R9 err pulse", 32'(err), 32'h1);
        check("R9 lamps held", 32'(data_lamp), 32'(held_d));
        @(negedge clk);
        check("R9 err clears", 32'(err), 32'h0);
        strike(3'd4, 16'h0777, 16'h0, 1'b0, 1'b1);
        check("R9 ic lamp held", 32'(ic_lamp), 32'(held_i));
        manual = 1'b1;
        strike(3'd3, 16'h0010, 16'h0, 1'b1, 1'b0);
        check("R9 ms untouched", 32'(data_lamp), 32'({msb(16), msb(17)}));
        strike(3'd4, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R9 ic untouched", 32'(ic_lamp), 32'h8ABC);
        // R10 R1: protection-key and unused codes
        held_d = data_lamp; held_i = ic_lamp;
        strike(3'd5, 16'h0010, 16'h2222, 1'b0, 1'b1);
        check("R10 key lamps", 32'(data_lamp), 32'(held_d));
        check("R10 key err", 32'(err), 32'h0);
        strike(3'd6, 16'h0010, 16'h2222, 1'b1, 1'b1);
        check("R1 code6 lamps", 32'(data_lamp), 32'(held_d));
        check("R1 code6 ic lamp", 32'(ic_lamp), 32'(held_i));
        strike(3'd3, 16'h0010, 16'h0, 1'b1, 1'b0);
        check("R10 ms untouched", 32'(data_lamp), 32'({msb(16), msb(17)}));
        // R11: both strobes perform the store
        strike(3'd3, 16'h0020, 16'h2468, 1'b1, 1'b1);
        check("R11 both echo", 32'(data_lamp), 32'h2468);
        strike(3'd3, 16'h0021, 16'h0, 1'b1, 1'b0);
        check("R11 both readback", 32'(data_lamp), 32'h2468);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule